// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block turns the 8-bit binary sum of two packed BCD bytes back into two valid decimal digits. It takes the accumulator value left by a binary addition together with the auxiliary-carry (carry out of bit 3) and carry flags that the addition produced. It returns the corrected byte and a full set of five result flags: sign, zero, auxiliary carry, parity and carry. Whether a digit is corrected depends on the flags as well as on the digit values. A digit that looks valid but carried during the addition is still corrected.

The correction itself is combinational. A low-digit stage adds 06h when needed and passes its 9-bit result on. A high-digit stage then tests that intermediate value and adds 60h. A flag generator derives the flags from the final byte. A registered output stage captures the result on the clock edge where `adj_strobe` is high and holds it at all other times. A two-state controller tracks whether the output register holds a result yet. It has two states. `ST_EMPTY` is entered at reset. The transition `EMPTY->LOADED`, taken on the first strobe, leads to `ST_LOADED`. `LOADED` stays in that state on every later strobe and also when there is no strobe. `res_valid` is high only in `ST_LOADED`.

Top module: `daa_unit`

## Requirements
- R1: When the low digit (bits 3:0) of `acc_in` is above 9 or `ac_in` is 1, 06h is added to the byte. Otherwise the low stage leaves the byte unchanged.
- R2: The high-digit test is made on the byte after the low correction. 60h is added when that value's bits 7:4 are above 9, when `cy_in` is 1, or when the low correction carried out of bit 7.
- R3: `flag_cy` is 1 whenever the high correction was applied, which means the decimal result is 100 or more. `cy_in`=1 always gives `flag_cy`=1.
- R4: `flag_ac` is the carry out of bit 3 produced by the low correction. It is 0 when no low correction was applied.
- R5: `flag_s` equals bit 7 of the adjusted byte. `flag_z` is 1 only when the adjusted byte is 00h. `flag_p` is 1 when the adjusted byte has an even number of ones.
- R6: The outputs take the new result at the clock edge where `adj_strobe` is 1. With `adj_strobe` at 0 they hold their value whatever the inputs do.
- R7: While `rst_n` is low, `acc_out`, all five flags and `res_valid` are 0.
- R8: `res_valid` rises at the first strobe edge after reset and then stays 1.
- R9: Input EDh with both flags 0 yields 53h with `flag_cy`=1 and `flag_ac`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adj_strobe | input | 1 | Capture the adjusted result at this edge |
| acc_in | input | 8 | Binary sum to be corrected |
| ac_in | input | 1 | Auxiliary carry left by the addition |
| cy_in | input | 1 | Carry left by the addition |
| acc_out | output | 8 | Adjusted packed BCD byte |
| flag_s | output | 1 | Sign of the adjusted byte |
| flag_z | output | 1 | Adjusted byte is zero |
| flag_ac | output | 1 | Carry out of bit 3 from the low correction |
| flag_p | output | 1 | Even parity of the adjusted byte |
| flag_cy | output | 1 | Decimal overflow / carried-in carry |
| res_valid | output | 1 | Output register holds a result |

## Verification
The hardest case to reach is a high correction that is triggered only by the low correction carrying out of bit 7. This needs a byte of FAh or more with an invalid low digit or `ac_in` set, together with `cy_in` low. Uniform random stimulus seldom lands there, so the bench drives FAh to FFh directly. It also drives bytes whose high digit is exactly 9 and whose low correction pushes it to A. Random bytes are mixed with biased flag inputs, and each result is compared with a reference function built from R1 to R5.

// File: rtl/daa_pkg.sv
package daa_pkg;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } daa_flags_t;

    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } daa_state_t;

endpackage

// File: rtl/daa_lo_stage.sv
module daa_lo_stage #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [2*DIGIT_W-1:0] val_in,
    input  logic                 ac_in,
    output logic [2*DIGIT_W:0]   mid_out,
    output logic                 ac_out
);
    localparam int WORD_W = 2 * DIGIT_W;
    localparam int CORR   = (1 << DIGIT_W) - RADIX;

    logic [DIGIT_W-1:0] lo_nib;
    logic               lo_fix;
    logic [DIGIT_W:0]   lo_wide;

    always_comb begin
        lo_nib  = val_in[DIGIT_W-1:0];
        lo_fix  = (lo_nib > DIGIT_W'(RADIX - 1)) || ac_in;
        lo_wide = {1'b0, lo_nib} + (lo_fix ? (DIGIT_W+1)'(CORR) : '0);
        ac_out  = lo_wide[DIGIT_W];
        mid_out = {1'b0, val_in} + (lo_fix ? (WORD_W+1)'(CORR) : '0);
    end

endmodule

// File: rtl/daa_hi_stage.sv
module daa_hi_stage #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [2*DIGIT_W:0]   mid_in,
    input  logic                 cy_in,
    output logic [2*DIGIT_W-1:0] val_out,
    output logic                 cy_out
);
    localparam int WORD_W = 2 * DIGIT_W;
    localparam int CORR   = (1 << DIGIT_W) - RADIX;

    logic [DIGIT_W-1:0] hi_nib;
    logic               hi_fix;
    logic [WORD_W:0]    total;

    always_comb begin
        hi_nib  = mid_in[WORD_W-1:DIGIT_W];
        hi_fix  = (hi_nib > DIGIT_W'(RADIX - 1)) || cy_in || mid_in[WORD_W];
        total   = {1'b0, mid_in[WORD_W-1:0]}
                + (hi_fix ? (WORD_W+1)'(CORR << DIGIT_W) : '0);
        val_out = total[WORD_W-1:0];
        cy_out  = cy_in || mid_in[WORD_W] || total[WORD_W];
    end

endmodule

// File: rtl/daa_flag_gen.sv
module daa_flag_gen
    import daa_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] val,
    input  logic              ac,
    input  logic              cy,
    output daa_flags_t        flags
);
    logic [WORD_W:0] par_chain;

    assign par_chain[0] = 1'b0;
    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_par
            assign par_chain[i+1] = par_chain[i] ^ val[i];
        end
    endgenerate

    always_comb begin
        flags.s  = val[WORD_W-1];
        flags.z  = (val == '0);
        flags.ac = ac;
        flags.p  = ~par_chain[WORD_W];
        flags.cy = cy;
    end

endmodule

// File: rtl/daa_unit.sv
module daa_unit
    import daa_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10,
    localparam int WORD_W = 2 * DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adj_strobe,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic [WORD_W-1:0] acc_out,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_ac,
    output logic              flag_p,
    output logic              flag_cy,
    output logic              res_valid
);
    logic [WORD_W:0]   mid;
    logic              lo_carry;
    logic [WORD_W-1:0] adj_val;
    logic              adj_cy;
    daa_flags_t        adj_flags;
    daa_flags_t        flag_q;
    logic [WORD_W-1:0] acc_q;
    daa_state_t        state_q, state_d;

    daa_lo_stage #(.DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_lo (
        .val_in (acc_in),
        .ac_in  (ac_in),
        .mid_out(mid),
        .ac_out (lo_carry)
    );

    daa_hi_stage #(.DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_hi (
        .mid_in (mid),
        .cy_in  (cy_in),
        .val_out(adj_val),
        .cy_out (adj_cy)
    );

    daa_flag_gen #(.WORD_W(WORD_W)) u_flags (
        .val  (adj_val),
        .ac   (lo_carry),
        .cy   (adj_cy),
        .flags(adj_flags)
    );

    // Controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (adj_strobe) state_d = ST_LOADED;
            ST_LOADED: state_d = ST_LOADED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= '0;
        end else if (adj_strobe) begin
            acc_q  <= adj_val;
            flag_q <= adj_flags;
        end
    end

    // Outputs
    always_comb begin
        acc_out   = acc_q;
        flag_s    = flag_q.s;
        flag_z    = flag_q.z;
        flag_ac   = flag_q.ac;
        flag_p    = flag_q.p;
        flag_cy   = flag_q.cy;
        res_valid = (state_q == ST_LOADED);
    end

endmodule

// File: rtl/daa_unit_chk.sv
module daa_unit_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adj_strobe,
    input logic [WORD_W-1:0] acc_in,
    input logic              ac_in,
    input logic              cy_in,
    input logic [WORD_W-1:0] acc_out,
    input logic              flag_s,
    input logic              flag_z,
    input logic              flag_ac,
    input logic              flag_p,
    input logic              flag_cy,
    input logic              res_valid
);
    localparam int HALF = WORD_W / 2;

    p_cy_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_strobe && cy_in) |=> flag_cy);

    p_clean_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_strobe && !ac_in && !cy_in && acc_in[HALF-1:0] <= 9 && acc_in[WORD_W-1:HALF] <= 9)
        |=> (acc_out == $past(acc_in) && !flag_cy && !flag_ac));

    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_s == acc_out[WORD_W-1]));

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_z == (acc_out == '0)));

    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_p == ~(^acc_out)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_strobe |=> ($stable(acc_out) && $stable(flag_cy) && $stable(flag_ac)));

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adj_strobe |=> res_valid);

    p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> res_valid);

endmodule

bind daa_unit daa_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adj_strobe(adj_strobe),
    .acc_in    (acc_in),
    .ac_in     (ac_in),
    .cy_in     (cy_in),
    .acc_out   (acc_out),
    .flag_s    (flag_s),
    .flag_z    (flag_z),
    .flag_ac   (flag_ac),
    .flag_p    (flag_p),
    .flag_cy   (flag_cy),
    .res_valid (res_valid)
);

// File: tb/daa_unit_tb.sv
module daa_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adj_strobe = 1'b0;
    logic [7:0] acc_in = '0;
    logic       ac_in = 1'b0;
    logic       cy_in = 1'b0;
    logic [7:0] acc_out;
    logic       flag_s, flag_z, flag_ac, flag_p, flag_cy, res_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    daa_unit u_dut (
        .clk(clk), .rst_n(rst_n), .adj_strobe(adj_strobe),
        .acc_in(acc_in), .ac_in(ac_in), .cy_in(cy_in),
        .acc_out(acc_out), .flag_s(flag_s), .flag_z(flag_z),
        .flag_ac(flag_ac), .flag_p(flag_p), .flag_cy(flag_cy),
        .res_valid(res_valid)
    );

    // Reference: {acc[7:0], s, z, ac, p, cy}
    function automatic logic [12:0] ref_adjust(input logic [7:0] a, input logic ac, input logic cy);
        logic       lo_fix, hi_fix, ac_o, cy_o;
        logic [8:0] v1;
        logic [7:0] v2;
        lo_fix = (a[3:0] > 4'd9) || ac;                     // R1
        v1     = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
        ac_o   = lo_fix && ({1'b0, a[3:0]} + 5'd6 > 5'd15);  // R4
        hi_fix = (v1[7:4] > 4'd9) || cy || v1[8];           // R2
        v2     = v1[7:0] + (hi_fix ? 8'h60 : 8'h00);
        cy_o   = hi_fix;                                    // R3
        return {v2, v2[7], (v2 == 8'h00), ac_o, ~(^v2), cy_o}; // R5
    endfunction

    function automatic logic [12:0] observed();
        return {acc_out, flag_s, flag_z, flag_ac, flag_p, flag_cy};
    endfunction

    task automatic check13(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [7:0] a, input logic ac, input logic cy);
        @(negedge clk);
        acc_in = a; ac_in = ac; cy_in = cy; adj_strobe = 1'b1;
        @(negedge clk);
        adj_strobe = 1'b0;
        check13(tag, observed(), ref_adjust(a, ac, cy));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [12:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7: reset state
        check13("R7 reset outputs", {observed(), 1'b0}, 14'h0);
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 res_valid actual=%b expected=0", res_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8 valid before strobe actual=%b expected=0", res_valid);
        end

        // R9: worked example
        apply("R9 EDh", 8'hED, 1'b0, 1'b0);
        check13("R9 EDh literal", observed(), {8'h53, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
        checks++;
        if (res_valid !== 1'b1) begin
            failures++;
            $display("FAIL R8 valid after strobe actual=%b expected=1", res_valid);
        end

        // R1/R4: low correction via flag only, via nibble
        apply("R1 ac only", 8'h12, 1'b1, 1'b0);
        check13("R1 ac only literal", {acc_out, flag_ac}, {8'h18, 1'b0, 4'h0} >> 4 | 13'(0) | {8'h18, 1'b0} );
        apply("R4 low carry", 8'h3C, 1'b0, 1'b0);
        check13("R4 3Ch literal", {acc_out, flag_ac}, {8'h42, 1'b1});
        // R2: high correction from low carry into high digit
        apply("R2 9Ah", 8'h9A, 1'b0, 1'b0);
        check13("R2 9Ah literal", {acc_out, flag_cy}, {8'h00, 1'b1});
        // R2: high correction from carry out of bit 7 of low stage
        for (int v = 8'hFA; v <= 8'hFF; v++) apply("R2 top range", 8'(v), 1'b0, 1'b0);
        apply("R2 FFh with ac", 8'hFF, 1'b1, 1'b0);
        // R3: cy_in on valid digits
        apply("R3 cy_in", 8'h25, 1'b0, 1'b1);
        check13("R3 cy_in literal", {acc_out, flag_cy}, {8'h85, 1'b1});
        // R5: zero and parity
        apply("R5 zero", 8'h00, 1'b0, 1'b0);
        check13("R5 zero literal", {flag_z, flag_p}, 13'b11);
        apply("R5 99h", 8'h99, 1'b0, 1'b0);

        // R6: hold when no strobe
        held = observed();
        @(negedge clk);
        acc_in = 8'hAB; ac_in = 1'b1; cy_in = 1'b1;
        repeat (3) @(negedge clk);
        check13("R6 hold", observed(), held);
        checks++;
        if (res_valid !== 1'b1) begin
            failures++;
            $display("FAIL R8 valid kept actual=%b expected=1", res_valid);
        end

        // Random sweep, flag inputs biased
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic ac, cy;
            a  = 8'($urandom);
            ac = ($urandom % 4) == 0;
            cy = ($urandom % 4) == 0;
            apply("R1 R2 R3 R4 R5 random", a, ac, cy);
        end

        // Exhaustive over bytes with both flag pairs
        for (int k = 0; k < 1024; k++)
            apply("R1 R2 R3 R4 R5 sweep", 8'(k), k[8], k[9]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule